// File: doc/BRIEF.md
# Programmable Time Tag Counter

This block keeps a 16-bit time stamp that advances at a programmable rate, so that message-handling logic can mark each message with the time it was handled. A prescaler turns the system clock into one-microsecond steps. The system clock may run at one of four frequencies, and the block is told which one through a select input. A second prescaler stage then groups those microseconds into one count step of 2 to 64 µs. The host can read the counter at any time and overwrite it. For self-test, the host can also stop the automatic advance and step the counter one count at a time.

Two synchronize actions come from the message logic. The first is a synchronize without data, which clears the counter. The second is a synchronize with data, which loads the received word. Each action has its own enable. The load can also be filtered so that only words with an even least significant bit are accepted. When the message logic pulses its capture input, the current count is latched into a snapshot output, which is stored as the time word of the descriptor. When the counter wraps from FFFF to 0000, the block pulses an interrupt request and sets a sticky status bit.

Top module: `time_tag_counter`

## Requirements
- R1: While reset is asserted and after it is released, `count`, `snapshot`, `roll_status` and `roll_irq` are all zero.
- R2: A host write loads `host_wdata` into `count` at the next clock edge. It takes priority over a synchronize action, an automatic tick and a software step in the same cycle. It also restarts the prescaler from zero.
- R3: `clk_sel` gives the clock cycles per microsecond: 0 → 10, 1 → 12, 2 → 16, 3 → 20.
- R4: `res_sel` gives the microseconds per count step: 0 → 2, 1 → 4, 2 → 8, 3 → 16, 4 → 32, 5 → 64, 6 and 7 → 64.
- R5: Outside software-step mode, with no restart, `count` rises by one every P cycles, where P is the product from R3 and R4. The first step comes exactly P cycles after the last restart.
- R6: While `sw_step_mode` is 1, the prescaler is held at zero. In this mode `count` advances only in a cycle in which `sw_step` is 1.
- R7: A step from FFFF to 0000 makes `roll_irq` high for exactly the one cycle in which `count` shows 0000. It also sets `roll_status`, which holds until a `roll_status_clr` pulse. A set wins over a clear in the same cycle. A write, clear or load that yields 0000 does not count as a wrap.
- R8: When `sync_clr_en` is 1, a `sync_nodata` pulse clears `count` and restarts the prescaler. When `sync_clr_en` is 0, the pulse has no effect. A clear beats a load in the same cycle.
- R9: When `sync_load_en` is 1, a `sync_data_valid` pulse loads `sync_data` into `count` and restarts the prescaler. When `sync_load_en` is 0, the pulse is ignored.
- R10: When `sync_filter_en` is 1, a sync load happens only if bit 0 of `sync_data` is 0. A word with bit 0 set leaves `count` unchanged.
- R11: A `msg_capture` pulse latches the value `count` had in that cycle into `snapshot`. `snapshot` holds that value until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | System clock frequency select |
| res_sel | input | 3 | Count resolution select |
| sw_step_mode | input | 1 | Selects software stepping instead of automatic advance |
| sw_step | input | 1 | One-count step command in software mode |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write value |
| count | output | 16 | Current counter value, readable by the host |
| sync_clr_en | input | 1 | Enables clear on synchronize without data |
| sync_load_en | input | 1 | Enables load on synchronize with data |
| sync_filter_en | input | 1 | Accepts only even load words |
| sync_nodata | input | 1 | Synchronize-without-data event |
| sync_data_valid | input | 1 | Synchronize-with-data event |
| sync_data | input | 16 | Data word of the synchronize event |
| msg_capture | input | 1 | Capture request from the message logic |
| snapshot | output | 16 | Count latched at the last capture |
| roll_status_clr | input | 1 | Clears the sticky wrap status |
| roll_status | output | 1 | Sticky wrap status |
| roll_irq | output | 1 | One-cycle wrap interrupt request |

## Verification
The hardest case to reach is a wrap that happens in the same cycle as another event, such as a status clear, a host write or a synchronize action. In automatic mode the wrap needs up to 65536 × 1280 cycles. The stimulus avoids this by writing FFFF or FFFE into the counter. It then either steps the counter in software mode or waits one short period in automatic mode. This places the wrap on a chosen cycle, where the competing event is driven. A behavioural model predicts every output on every clock. It checks the prescaler period for all clock and resolution selections, including the encodings that reuse 64 µs.

// File: rtl/time_tag_counter.sv
module time_tag_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   clk_sel,
  input  logic [2:0]   res_sel,
  input  logic         sw_step_mode,
  input  logic         sw_step,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] count,
  input  logic         sync_clr_en,
  input  logic         sync_load_en,
  input  logic         sync_filter_en,
  input  logic         sync_nodata,
  input  logic         sync_data_valid,
  input  logic [W-1:0] sync_data,
  input  logic         msg_capture,
  output logic [W-1:0] snapshot,
  input  logic         roll_status_clr,
  output logic         roll_status,
  output logic         roll_irq
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [4:0] us_cnt, us_lim;
  logic [5:0] res_cnt, res_lim;
  logic       clr_hit, load_hit, restart, us_wrap, tick, step, wrap;

  always_comb begin
    case (clk_sel)
      2'd0:    us_lim = 5'd9;
      2'd1:    us_lim = 5'd11;
      2'd2:    us_lim = 5'd15;
      default: us_lim = 5'd19;
    endcase
    case (res_sel)
      3'd0:    res_lim = 6'd1;
      3'd1:    res_lim = 6'd3;
      3'd2:    res_lim = 6'd7;
      3'd3:    res_lim = 6'd15;
      3'd4:    res_lim = 6'd31;
      default: res_lim = 6'd63;
    endcase
  end

  assign clr_hit  = sync_nodata & sync_clr_en;
  assign load_hit = sync_data_valid & sync_load_en & ~(sync_filter_en & sync_data[0]);
  assign restart  = host_wr | clr_hit | load_hit | sw_step_mode;
  assign us_wrap  = us_cnt >= us_lim;
  assign tick     = ~restart & us_wrap & (res_cnt >= res_lim);
  assign step     = sw_step_mode ? sw_step : tick;
  assign wrap     = step & (count == ALL_ONES) & ~host_wr & ~clr_hit & ~load_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_cnt  <= '0;
      res_cnt <= '0;
    end else if (restart) begin
      us_cnt  <= '0;
      res_cnt <= '0;
    end else if (us_wrap) begin
      us_cnt  <= '0;
      res_cnt <= (res_cnt >= res_lim) ? 6'd0 : res_cnt + 6'd1;
    end else begin
      us_cnt  <= us_cnt + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (host_wr)    count <= host_wdata;
    else if (clr_hit)    count <= '0;
    else if (load_hit)   count <= sync_data;
    else if (step)       count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snapshot    <= '0;
      roll_status <= 1'b0;
      roll_irq    <= 1'b0;
    end else begin
      if (msg_capture) snapshot <= count;
      roll_status <= wrap | (roll_status & ~roll_status_clr);
      roll_irq    <= wrap;
    end
  end

  // R2
  host_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> count == $past(host_wdata));

  // R8
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_nodata && sync_clr_en && !host_wr) |=> count == '0);

  // R6
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_step_mode && !sw_step && !host_wr && !sync_nodata && !sync_data_valid)
      |=> count == $past(count));

  // R7
  irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll_irq |-> (count == '0 && roll_status));

  // R11
  snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_capture |=> snapshot == $past(count));

  // R10
  filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_data_valid && sync_filter_en && sync_data[0] && !sync_nodata && !host_wr
      && sw_step_mode && !sw_step) |=> count == $past(count));

endmodule

// File: tb/test_time_tag_counter.sv
module test_time_tag_counter;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  clk_sel = 0;
  logic [2:0]  res_sel = 0;
  logic        sw_step_mode = 0, sw_step = 0, host_wr = 0;
  logic [15:0] host_wdata = 0, sync_data = 0;
  logic        sync_clr_en = 0, sync_load_en = 0, sync_filter_en = 0;
  logic        sync_nodata = 0, sync_data_valid = 0, msg_capture = 0, roll_status_clr = 0;
  logic [15:0] count, snapshot;
  logic        roll_status, roll_irq;

  time_tag_counter i_time_tag_counter (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .res_sel(res_sel),
    .sw_step_mode(sw_step_mode), .sw_step(sw_step), .host_wr(host_wr),
    .host_wdata(host_wdata), .count(count), .sync_clr_en(sync_clr_en),
    .sync_load_en(sync_load_en), .sync_filter_en(sync_filter_en),
    .sync_nodata(sync_nodata), .sync_data_valid(sync_data_valid),
    .sync_data(sync_data), .msg_capture(msg_capture), .snapshot(snapshot),
    .roll_status_clr(roll_status_clr), .roll_status(roll_status), .roll_irq(roll_irq));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  int m_cnt = 0, m_snap = 0, m_pre = 0;
  bit m_st = 0, m_irq = 0;

  function automatic int period();
    int mhz, us;
    mhz = (clk_sel == 0) ? 10 : (clk_sel == 1) ? 12 : (clk_sel == 2) ? 16 : 20;
    us  = (res_sel > 5) ? 64 : (2 << res_sel);
    return mhz * us;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_snap = 0; m_pre = 0; m_st = 0; m_irq = 0;
    end else begin
      bit clr, ld, rs, stp, wr;
      int p;
      p   = period();
      clr = sync_nodata && sync_clr_en;
      ld  = sync_data_valid && sync_load_en && !(sync_filter_en && sync_data[0]);
      rs  = host_wr || clr || ld || sw_step_mode;
      stp = sw_step_mode ? sw_step : (!rs && m_pre == p - 1);
      m_pre = (rs || m_pre >= p - 1) ? 0 : m_pre + 1;
      if (msg_capture) m_snap = m_cnt;
      wr = 0;
      if (host_wr) m_cnt = host_wdata;
      else if (clr) m_cnt = 0;
      else if (ld) m_cnt = sync_data;
      else if (stp) begin
        if (m_cnt == 65535) begin m_cnt = 0; wr = 1; end
        else m_cnt = m_cnt + 1;
      end
      m_st  = wr || (m_st && !roll_status_clr);
      m_irq = wr;
    end
  end

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("count", int'(count), m_cnt);
      chk("snapshot", int'(snapshot), m_snap);
      chk("roll_status", int'(roll_status), int'(m_st));
      chk("roll_irq", int'(roll_irq), int'(m_irq));
    end
  end

  task automatic tk(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic hwrite(logic [15:0] v);
    host_wr = 1; host_wdata = v; tk(1); host_wr = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tk(3);
    cur_req = "R1";
    chk("reset count", int'(count), 0);
    chk("reset irq", int'(roll_irq), 0);
    rst_n = 1;
    tk(1);
    chk("post-reset snapshot", int'(snapshot), 0);
    chk("post-reset status", int'(roll_status), 0);

    cur_req = "R3";
    for (int c = 0; c < 4; c++) begin
      clk_sel = 2'(c); res_sel = 0; hwrite(16'h0010);
      tk(3 * period() + 4);
    end
    cur_req = "R4";
    for (int r = 0; r < 8; r++) begin
      clk_sel = 0; res_sel = 3'(r); hwrite(16'h0100);
      tk(2 * period() + 3);
    end
    cur_req = "R5";
    clk_sel = 3; res_sel = 5; hwrite(16'h0000);
    tk(period() + 2);

    cur_req = "R2";
    clk_sel = 0; res_sel = 0; hwrite(16'h1234);
    tk(19);
    host_wr = 1; host_wdata = 16'hABCD; sync_clr_en = 1; sync_nodata = 1; tk(1);
    host_wr = 0; sync_nodata = 0;
    tk(25);

    cur_req = "R6";
    sw_step_mode = 1; tk(60);
    sw_step = 1; tk(3); sw_step = 0; tk(5);
    sw_step = 1; host_wr = 1; host_wdata = 16'h0042; tk(1);
    sw_step = 0; host_wr = 0; tk(2);

    cur_req = "R7";
    hwrite(16'hFFFE);
    sw_step = 1; tk(1); sw_step = 0; tk(1);
    sw_step = 1; tk(1); sw_step = 0; tk(4);
    roll_status_clr = 1; tk(1); roll_status_clr = 0; tk(2);
    hwrite(16'hFFFF);
    sw_step = 1; roll_status_clr = 1; tk(1); sw_step = 0; roll_status_clr = 0; tk(3);
    roll_status_clr = 1; tk(1); roll_status_clr = 0;
    hwrite(16'h0000); tk(2);
    sw_step_mode = 0; hwrite(16'hFFFF); tk(period() + 3);
    roll_status_clr = 1; tk(1); roll_status_clr = 0; tk(2);

    cur_req = "R8";
    hwrite(16'h5555);
    sync_clr_en = 0; sync_nodata = 1; tk(1); sync_nodata = 0; tk(3);
    sync_clr_en = 1; tk(7); sync_nodata = 1; tk(1); sync_nodata = 0; tk(25);
    sync_load_en = 1; sync_nodata = 1; sync_data_valid = 1; sync_data = 16'h0200;
    tk(1); sync_nodata = 0; sync_data_valid = 0; tk(3);

    cur_req = "R9";
    sync_load_en = 0; sync_data = 16'h7000; sync_data_valid = 1; tk(1); sync_data_valid = 0; tk(3);
    sync_load_en = 1; tk(11); sync_data_valid = 1; tk(1); sync_data_valid = 0; tk(30);

    cur_req = "R10";
    sync_filter_en = 1;
    sync_data = 16'h0333; sync_data_valid = 1; tk(1); sync_data_valid = 0; tk(5);
    sync_data = 16'h0334; sync_data_valid = 1; tk(1); sync_data_valid = 0; tk(5);
    sync_filter_en = 0;
    sync_data = 16'h0335; sync_data_valid = 1; tk(1); sync_data_valid = 0; tk(5);

    cur_req = "R11";
    msg_capture = 1; tk(1); msg_capture = 0; tk(30);
    msg_capture = 1; tk(3); msg_capture = 0; tk(4);
    hwrite(16'h0999); msg_capture = 1; host_wr = 1; host_wdata = 16'h0AAA; tk(1);
    msg_capture = 0; host_wr = 0; tk(5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule